// File: doc/BRIEF.md
# Stereo Digital Volume Attenuator with Soft Mute

This block is a gain stage for a two-channel PCM stream. Each channel has its own 8-bit level code. The block turns that code into a logarithmic gain in half-decibel steps, from 0 dB down to -120 dB. Codes at the bottom of the range silence the channel. Samples are 24-bit two's complement words, and each arrives with a single strobe shared by both channels. Shorter source words are left-aligned into the 24 bits before they reach the block. Each scaled pair appears one clock after its strobe.

The gain never jumps. On each sample strobe, the applied level moves one half-decibel step toward its target. A soft-mute request sets the target of both channels to the silent level, so the output fades out over a number of samples. A zero detector on each channel counts consecutive all-zero input samples and raises a flag after a programmable run length. When zero-mute is enabled and both flags are up, the block enters the same fade to silence. The fade reverses once either flag drops. A status output reports when a requested mute has fully reached silence on both channels.

Top module: `vol_atten_stereo`

## Requirements
- R1: `out_valid` is high exactly in the clock after each cycle with `in_valid` high. `out_l` and `out_r` change only in such clocks.
- R2: For an applied level c in 15..255, let a = 255 - c and T[k] = round(65536 * 10^(-k/40)). The output is floor((x * T[a mod 12] + 2^(s-1)) / 2^s) with s = 16 + floor(a/12), and x is the signed input sample.
- R3: An attenuation code from 0 to 14 selects silence. The applied level never falls below 14, and an applied level of 14 gives an output of exactly 0.
- R4: At reset the applied level of each channel is 255. On each strobe, the output is computed with the level in force before that strobe. The level then moves one step (+1 or -1) toward the target, or holds if it already equals the target.
- R5: While `soft_mute` is high, the target of both channels is 14. `mute_done` is high exactly when a mute is requested and both applied levels equal 14.
- R6: Each channel's zero flag goes high in the clock after the ZERO_RUN-th consecutive all-zero sample on that channel. It goes low in the clock after that channel's first nonzero sample.
- R7: When `zero_mute_en` is high and both zero flags are high, the block requests a mute with the same targets as soft mute. If only one flag is high, no mute is requested.
- R8: While reset is active and right after it, `out_valid`, both outputs, both zero flags and `mute_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample strobe for both channels |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| atten_l | input | 8 | Left level code, 255 = 0 dB, -0.5 dB per step |
| atten_r | input | 8 | Right level code |
| soft_mute | input | 1 | Request a fade to silence |
| zero_mute_en | input | 1 | Allow both zero flags to force the fade |
| out_valid | output | 1 | Scaled pair valid |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| zero_flag_l | output | 1 | Left zero-run flag |
| zero_flag_r | output | 1 | Right zero-run flag |
| mute_done | output | 1 | Requested mute has reached silence on both channels |

## Verification
The bench builds the block with a zero run length of 16 instead of the default 1024. This lets flag set, flag clear and the automatic fade all happen many times within a short run. The sample width and code width stay at their default values of 24 and 8. As a result, every one of the 241 audible levels, both full-scale sample extremes and the complete 241-step fade are reached and checked as built.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int unsigned LVL_W         = 8;
  localparam int unsigned GAIN_W        = 17;
  localparam int unsigned GAIN_FRAC     = 16;
  localparam int unsigned STEPS_PER_OCT = 12;
  localparam logic [LVL_W-1:0] LVL_MAX  = 8'd255;
  localparam logic [LVL_W-1:0] LVL_MUTE = 8'd14;

  // Mantissa of the gain within one 6 dB octave, Q1.16
  function automatic logic [GAIN_W-1:0] gain_mant(input logic [3:0] k);
    logic [GAIN_W-1:0] g;
    case (k)
      4'd0:    g = 17'd65536;
      4'd1:    g = 17'd61870;
      4'd2:    g = 17'd58409;
      4'd3:    g = 17'd55142;
      4'd4:    g = 17'd52057;
      4'd5:    g = 17'd49145;
      4'd6:    g = 17'd46396;
      4'd7:    g = 17'd43801;
      4'd8:    g = 17'd41350;
      4'd9:    g = 17'd39037;
      4'd10:   g = 17'd36854;
      default: g = 17'd34792;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/vol_ramp.sv
module vol_ramp
  import vol_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [LVL_W-1:0] target,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] level_nxt;

  always_comb begin
    level_nxt = level;
    if (step_en) begin
      if (level < target)      level_nxt = level + 1'b1;
      else if (level > target) level_nxt = level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= LVL_MAX;
    else        level <= level_nxt;
  end
endmodule

// File: rtl/vol_scale.sv
module vol_scale
  import vol_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic [DW-1:0]    sample,
  input  logic [LVL_W-1:0] level,
  output logic [DW-1:0]    scaled
);
  localparam int unsigned PW = DW + GAIN_W + 1;

  logic [LVL_W-1:0]      atten;
  logic [3:0]            idx;
  logic [5:0]            shamt;
  logic signed [PW-1:0]  prod;
  logic signed [PW:0]    rnd;
  logic signed [PW:0]    sum;
  logic signed [PW:0]    shifted;

  always_comb begin
    atten   = LVL_MAX - level;
    idx     = 4'(atten % LVL_W'(STEPS_PER_OCT));
    shamt   = 6'(GAIN_FRAC) + 6'(atten / LVL_W'(STEPS_PER_OCT));
    prod    = PW'($signed(sample)) * PW'($signed({1'b0, gain_mant(idx)}));
    rnd     = '0;
    rnd[shamt - 6'd1] = 1'b1;
    sum     = {prod[PW-1], prod} + rnd;
    shifted = sum >>> shamt;
    if (level <= LVL_MUTE) scaled = '0;
    else                   scaled = shifted[DW-1:0];
  end
endmodule

// File: rtl/vol_zero_det.sv
module vol_zero_det #(
  parameter int unsigned DW       = 24,
  parameter int unsigned ZERO_RUN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [DW-1:0] sample,
  output logic          flag
);
  localparam int unsigned CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_RUN);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (strobe) begin
      if (sample != '0)        cnt_nxt = '0;
      else if (cnt != CNT_TOP) cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign flag = (cnt == CNT_TOP);
endmodule

// File: rtl/vol_atten_stereo.sv
module vol_atten_stereo
  import vol_pkg::*;
#(
  parameter int unsigned DW       = 24,
  parameter int unsigned ZERO_RUN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  input  logic [7:0]    atten_l,
  input  logic [7:0]    atten_r,
  input  logic          soft_mute,
  input  logic          zero_mute_en,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic          zero_flag_l,
  output logic          zero_flag_r,
  output logic          mute_done
);
  localparam int unsigned NCH = 2;

  logic [1:0]       rst_sync;
  logic             rst_i;
  logic [DW-1:0]    smp    [NCH];
  logic [LVL_W-1:0] code   [NCH];
  logic [LVL_W-1:0] target [NCH];
  logic [LVL_W-1:0] lvl    [NCH];
  logic [DW-1:0]    scaled [NCH];
  logic [DW-1:0]    out_q  [NCH];
  logic [DW-1:0]    out_d  [NCH];
  logic [NCH-1:0]   zflag;
  logic             mute_req;
  logic             valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign smp[0]  = in_l;
  assign smp[1]  = in_r;
  assign code[0] = atten_l;
  assign code[1] = atten_r;

  assign mute_req = soft_mute | (zero_mute_en & (&zflag));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb begin
      if (mute_req || code[ch] <= LVL_MUTE) target[ch] = LVL_MUTE;
      else                                  target[ch] = code[ch];
    end

    vol_ramp u_ramp (
      .clk     (clk),
      .rst_n   (rst_i),
      .step_en (in_valid),
      .target  (target[ch]),
      .level   (lvl[ch])
    );

    vol_scale #(.DW(DW)) u_scale (
      .sample (smp[ch]),
      .level  (lvl[ch]),
      .scaled (scaled[ch])
    );

    vol_zero_det #(.DW(DW), .ZERO_RUN(ZERO_RUN)) u_zdet (
      .clk    (clk),
      .rst_n  (rst_i),
      .strobe (in_valid),
      .sample (smp[ch]),
      .flag   (zflag[ch])
    );

    always_comb out_d[ch] = in_valid ? scaled[ch] : out_q[ch];

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) out_q[ch] <= '0;
      else        out_q[ch] <= out_d[ch];
    end
  end

  always_comb valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  assign out_l       = out_q[0];
  assign out_r       = out_q[1];
  assign zero_flag_l = zflag[0];
  assign zero_flag_r = zflag[1];
  assign mute_done   = mute_req & (lvl[0] == LVL_MUTE) & (lvl[1] == LVL_MUTE);
endmodule

module vol_atten_stereo_chk
  import vol_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input logic             clk,
  input logic             rst_i,
  input logic             in_valid,
  input logic [DW-1:0]    in_l,
  input logic [DW-1:0]    in_r,
  input logic             out_valid,
  input logic [DW-1:0]    out_l,
  input logic [DW-1:0]    out_r,
  input logic             zero_flag_l,
  input logic             zero_flag_r,
  input logic             mute_done,
  input logic [LVL_W-1:0] lvl_l,
  input logic [LVL_W-1:0] lvl_r
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid |=> out_valid); // R1
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    !in_valid |=> ($stable(out_l) && $stable(out_r))); // R1
  AST_LEVEL_FLOOR: assert property (@(posedge clk) disable iff (!rst_i)
    (lvl_l >= LVL_MUTE) && (lvl_r >= LVL_MUTE)); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    !in_valid |=> ($stable(lvl_l) && $stable(lvl_r))); // R4
  AST_SILENT_OUT: assert property (@(posedge clk) disable iff (!rst_i)
    (mute_done && in_valid) |=> (out_l == '0 && out_r == '0)); // R5
  AST_FLAG_CLEAR_L: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_l != '0) |=> !zero_flag_l); // R6
  AST_FLAG_CLEAR_R: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_r != '0) |=> !zero_flag_r); // R6
endmodule

bind vol_atten_stereo vol_atten_stereo_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_i       (rst_i),
  .in_valid    (in_valid),
  .in_l        (in_l),
  .in_r        (in_r),
  .out_valid   (out_valid),
  .out_l       (out_l),
  .out_r       (out_r),
  .zero_flag_l (zero_flag_l),
  .zero_flag_r (zero_flag_r),
  .mute_done   (mute_done),
  .lvl_l       (lvl[0]),
  .lvl_r       (lvl[1])
);

// File: tb/vol_atten_stereo_bench.sv
module vol_atten_stereo_bench;
  localparam int ZR = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_l, in_r;
  logic [7:0]  atten_l, atten_r;
  logic        soft_mute, zero_mute_en;
  logic        out_valid;
  logic [23:0] out_l, out_r;
  logic        zero_flag_l, zero_flag_r, mute_done;

  int checks = 0;
  int errors = 0;

  int m_lvl [2];
  int m_cnt [2];

  always #4 clk = ~clk;

  vol_atten_stereo #(.DW(24), .ZERO_RUN(ZR)) u_vol_atten_stereo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .atten_l(atten_l), .atten_r(atten_r), .soft_mute(soft_mute),
    .zero_mute_en(zero_mute_en), .out_valid(out_valid), .out_l(out_l),
    .out_r(out_r), .zero_flag_l(zero_flag_l), .zero_flag_r(zero_flag_r),
    .mute_done(mute_done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_scale(input longint x, input int lvl);
    int     a, sh;
    longint g, p;
    if (lvl <= 14) return 0;
    a  = 255 - lvl;
    g  = longint'($rtoi(65536.0 * (10.0 ** (-(real'(a % 12)) / 40.0)) + 0.5));
    sh = 16 + a / 12;
    p  = x * g;
    return (p + (64'sd1 <<< (sh - 1))) >>> sh;
  endfunction

  function automatic bit m_flag(input int ch);
    return m_cnt[ch] == ZR;
  endfunction

  function automatic bit m_req();
    return soft_mute || (zero_mute_en && m_flag(0) && m_flag(1));
  endfunction

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    longint exp_o [2];
    longint xs    [2];
    int     codes [2];
    bit     req;
    xs[0] = longint'($signed(l)); xs[1] = longint'($signed(r));
    codes[0] = int'(atten_l); codes[1] = int'(atten_r);
    @(negedge clk);
    in_l = l; in_r = r; in_valid = 1'b1;
    req = m_req();
    for (int ch = 0; ch < 2; ch++) begin
      int tgt;
      exp_o[ch] = ref_scale(xs[ch], m_lvl[ch]);
      tgt = (req || codes[ch] <= 14) ? 14 : codes[ch];
      if (m_lvl[ch] < tgt)      m_lvl[ch]++;
      else if (m_lvl[ch] > tgt) m_lvl[ch]--;
      if (xs[ch] != 0)    m_cnt[ch] = 0;
      else if (m_cnt[ch] != ZR) m_cnt[ch]++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid", longint'(out_valid), 1);
    check("R2/R3/R4 out_l", longint'($signed(out_l)), exp_o[0]);
    check("R2/R3/R4 out_r", longint'($signed(out_r)), exp_o[1]);
    check("R6 zero_flag_l", longint'(zero_flag_l), longint'(m_flag(0)));
    check("R6 zero_flag_r", longint'(zero_flag_r), longint'(m_flag(1)));
    check("R5/R7 mute_done", longint'(mute_done),
          longint'(m_req() && m_lvl[0] == 14 && m_lvl[1] == 14));
  endtask

  function automatic logic [23:0] rnd_sample();
    int sel;
    sel = int'($urandom_range(0, 7));
    if (sel == 0) return 24'h7FFFFF;
    if (sel == 1) return 24'h800000;
    if (sel == 2) return {16'($urandom), 8'h00};
    return 24'($urandom);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] hold_l;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_l = '0; in_r = '0;
    atten_l = 8'd255; atten_r = 8'd255; soft_mute = 1'b0; zero_mute_en = 1'b0;
    m_lvl[0] = 255; m_lvl[1] = 255; m_cnt[0] = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    check("R8 out_valid", longint'(out_valid), 0);
    check("R8 out_l", longint'(out_l), 0);
    check("R8 flags", longint'({zero_flag_l, zero_flag_r}), 0);
    check("R8 mute_done", longint'(mute_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 out_r after release", longint'(out_r), 0);

    // R2: unity gain extremes
    send(24'h7FFFFF, 24'h800000);
    send(24'h800000, 24'h7FFFFF);
    for (int i = 0; i < 40; i++) send(rnd_sample(), rnd_sample());

    // R1: hold between strobes
    hold_l = out_l;
    repeat (3) @(negedge clk);
    check("R1 out_valid idle", longint'(out_valid), 0);
    check("R1 out_l held", longint'(out_l), longint'(hold_l));

    // R2 R3 R4: random codes with ramp tracking
    for (int b = 0; b < 12; b++) begin
      atten_l = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 14)) : 8'($urandom);
      atten_r = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 14)) : 8'($urandom);
      for (int i = 0; i < 250; i++) send(rnd_sample(), rnd_sample());
    end

    // R5: full fade from 0 dB and recovery
    atten_l = 8'd255; atten_r = 8'd255;
    for (int i = 0; i < 245; i++) send(rnd_sample(), rnd_sample());
    soft_mute = 1'b1;
    for (int i = 0; i < 245; i++) send(rnd_sample(), rnd_sample());
    check("R5 mute_done at end of fade", longint'(mute_done), 1);
    soft_mute = 1'b0;
    for (int i = 0; i < 30; i++) send(rnd_sample(), rnd_sample());

    // R6: zero runs, flag set and clear
    for (int i = 0; i < ZR + 2; i++) send(24'h0, 24'h000100);
    check("R6 left flagged", longint'(zero_flag_l), 1);
    send(24'h000001, 24'h0);
    check("R6 left cleared", longint'(zero_flag_l), 0);

    // R7: one flag only gives no mute, both flags fade, release recovers
    zero_mute_en = 1'b1;
    for (int i = 0; i < ZR + 5; i++) send(24'h0, 24'h123456);
    check("R7 single flag no mute", longint'(mute_done), 0);
    for (int i = 0; i < 260; i++) send(24'h0, 24'h0);
    check("R7 auto mute reached", longint'(mute_done), 1);
    for (int i = 0; i < 20; i++) send(rnd_sample(), rnd_sample());
    check("R7 released", longint'(mute_done), 0);
    zero_mute_en = 1'b0;
    for (int i = 0; i < ZR + 3; i++) send(24'h0, 24'h0);
    check("R7 disabled no mute", longint'(mute_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule